// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a host processor indirect access to the private control registers inside a PHY. The PHY exposes them over a narrow request/acknowledge bus with 16-bit addresses and 16-bit data. The host does not drive that bus directly. It works through a few memory-mapped registers: a staging word, a result word and four trigger bits.

The host puts a PHY address into the staging word and fires the address-capture trigger. To write, it then stages the value, fires the data-capture trigger and finally fires the commit-write trigger. To read, it fires the read trigger after the address capture and then picks up the result word.

Each trigger bit stays set while its PHY transaction is in flight and drops by itself when the PHY has finished. Software therefore polls the trigger bit to know when the transaction is done. Only one transaction is in flight at any time.

Top module: `phy_creg_bridge`

## Requirements
- R1: After reset, all four trigger bits read 0, the result word reads 0 and every PHY strobe is low.
- R2: Host offsets: staging word 0x3C (read/write, all 32 bits read back), result word 0x40 (read only), address capture 0x44, data capture 0x48, read 0x4C, commit write 0x50. Each trigger is in bit 0 and bits 31:1 of a trigger read back as 0.
- R3: A host write with bit 0 set to an idle trigger raises the matching PHY strobe on the next clock, and the trigger then reads 1.
- R4: A strobe stays high until the PHY acknowledge is seen, and drops on the following clock. The trigger bit keeps reading 1 while the acknowledge is high, and reads 0 only after the acknowledge has fallen.
- R5: The PHY data bus carries bits 15:0 of the staging word. Address and data captures therefore deliver only those bits, and bits 31:16 have no effect on the PHY.
- R6: The result word takes the PHY read data when a read strobe is acknowledged, zero-extended to 32 bits. It is left unchanged by every other event.
- R7: A trigger write that arrives while a transaction is busy has no effect: no strobe is issued for it and its bit stays 0. A trigger write with bit 0 clear has no effect either.
- R8: At most one of the four PHY strobes is high in any cycle.
- R9: A full sequence of address capture, data capture and commit write, followed by a sequence of address capture and read, returns the written value from a single read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | HAW | Host register offset |
| host_wdata | input | HDW | Host write data |
| host_rdata | output | HDW | Host read data for `host_addr` |
| phy_dat_o | output | PDW | Staging word bits toward the PHY |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Commit-write strobe |
| phy_dat_i | input | PDW | PHY read data |
| phy_ack | input | 1 | PHY acknowledge |

## Verification
The bench builds the block with its default widths: an 8-bit host offset, a 32-bit host word and a 16-bit PHY bus. With these widths, all six offsets are reachable, and random upper halves of the staging word exercise the truncation onto the PHY bus. A PHY model in the bench acknowledges after a programmable delay, from zero to several cycles. This covers both a fast PHY and a long busy window, and the long window is where overlapping triggers are tried. The model also counts the strobes it serves, so ignored triggers show up at the PHY edge.

// File: rtl/phy_creg_bridge.sv
module phy_creg_bridge #(
  parameter int HAW = 8,
  parameter int HDW = 32,
  parameter int PDW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [HDW-1:0] host_wdata,
  output logic [HDW-1:0] host_rdata,
  output logic [PDW-1:0] phy_dat_o,
  output logic           phy_cap_addr,
  output logic           phy_cap_data,
  output logic           phy_rd,
  output logic           phy_wr,
  input  logic [PDW-1:0] phy_dat_i,
  input  logic           phy_ack
);
  localparam logic [HAW-1:0] OFS_DIN  = HAW'(8'h3C);
  localparam logic [HAW-1:0] OFS_DOUT = HAW'(8'h40);
  localparam logic [HAW-1:0] OFS_CAPA = HAW'(8'h44);
  localparam logic [HAW-1:0] OFS_CAPD = HAW'(8'h48);
  localparam logic [HAW-1:0] OFS_RD   = HAW'(8'h4C);
  localparam logic [HAW-1:0] OFS_WR   = HAW'(8'h50);
  localparam logic [1:0] OP_CAPA = 2'd0, OP_CAPD = 2'd1, OP_RD = 2'd2, OP_WR = 2'd3;

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_REL} phase_t;

  phase_t         ph_q;
  logic [1:0]     op_q;
  logic [HDW-1:0] din_q;
  logic [PDW-1:0] dout_q;
  logic           trig_hit;
  logic [1:0]     trig_op;
  logic           start;
  logic [3:0]     stb;
  logic [3:0]     busy;

  always_comb begin
    trig_hit = 1'b1;
    trig_op  = OP_CAPA;
    case (host_addr)
      OFS_CAPA: trig_op = OP_CAPA;
      OFS_CAPD: trig_op = OP_CAPD;
      OFS_RD:   trig_op = OP_RD;
      OFS_WR:   trig_op = OP_WR;
      default:  trig_hit = 1'b0;
    endcase
  end

  assign start = host_we && trig_hit && host_wdata[0] && (ph_q == P_IDLE);
  assign stb   = (ph_q == P_REQ)  ? (4'd1 << op_q) : 4'd0;
  assign busy  = (ph_q != P_IDLE) ? (4'd1 << op_q) : 4'd0;

  assign phy_cap_addr = stb[OP_CAPA];
  assign phy_cap_data = stb[OP_CAPD];
  assign phy_rd       = stb[OP_RD];
  assign phy_wr       = stb[OP_WR];
  assign phy_dat_o    = din_q[PDW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= P_IDLE;
      op_q   <= OP_CAPA;
      din_q  <= '0;
      dout_q <= '0;
    end else begin
      if (host_we && host_addr == OFS_DIN) din_q <= host_wdata;
      case (ph_q)
        P_IDLE: if (start) begin
          ph_q <= P_REQ;
          op_q <= trig_op;
        end
        P_REQ: if (phy_ack) begin
          ph_q <= P_REL;
          if (op_q == OP_RD) dout_q <= phy_dat_i;
        end
        P_REL: if (!phy_ack) ph_q <= P_IDLE;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    case (host_addr)
      OFS_DIN:  host_rdata = din_q;
      OFS_DOUT: host_rdata = HDW'(dout_q);
      OFS_CAPA: host_rdata = HDW'(busy[OP_CAPA]);
      OFS_CAPD: host_rdata = HDW'(busy[OP_CAPD]);
      OFS_RD:   host_rdata = HDW'(busy[OP_RD]);
      OFS_WR:   host_rdata = HDW'(busy[OP_WR]);
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_creg_bridge_chk.sv
module phy_creg_bridge_chk #(
  parameter int PDW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [3:0]     stb,
  input logic           phy_ack,
  input logic [PDW-1:0] dout
);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stb) && !phy_ack) |=> $stable(stb));

  p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stb) && phy_ack) |=> !(|stb));

  p_fall_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|stb) |-> $past(phy_ack));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb[2] && phy_ack) |=> $stable(dout));
endmodule

bind phy_creg_bridge phy_creg_bridge_chk #(.PDW(PDW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stb     ({phy_wr, phy_rd, phy_cap_data, phy_cap_addr}),
  .phy_ack (phy_ack),
  .dout    (dout_q)
);

// File: tb/test_phy_creg_bridge.sv
module test_phy_creg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DIN = 8'h3C, A_DOUT = 8'h40, A_CAPA = 8'h44,
                         A_CAPD = 8'h48, A_RD = 8'h4C, A_WR = 8'h50;

  logic        clk = 0, rst_n = 0, host_we = 0;
  logic [7:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [15:0] phy_dat_o, phy_dat_i;
  logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr, phy_ack;

  int checks = 0, fails = 0;
  int ack_dly = 1;
  int cnt;
  int rd_cnt, wr_cnt;
  logic [15:0] m_addr, m_data;
  logic [15:0] phy_mem [64];
  logic [15:0] exp_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_creg_bridge i_phy_creg_bridge (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .phy_dat_o, .phy_cap_addr, .phy_cap_data, .phy_rd, .phy_wr,
    .phy_dat_i, .phy_ack
  );

  function automatic logic [15:0] seed_val(int i);
    return 16'h3C96 ^ 16'(i * 16'h0101);
  endfunction

  wire any_stb = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      phy_ack <= 0; cnt <= 0; rd_cnt <= 0; wr_cnt <= 0;
      phy_dat_i <= 16'hDEAD; m_addr <= 0; m_data <= 0;
    end else if (!phy_ack && any_stb) begin
      if (cnt <= 0) begin
        phy_ack <= 1; cnt <= ack_dly;
        if (phy_cap_addr) m_addr <= phy_dat_o;
        if (phy_cap_data) m_data <= phy_dat_o;
        if (phy_wr) begin phy_mem[m_addr[5:0]] <= m_data; wr_cnt <= wr_cnt + 1; end
        if (phy_rd) begin phy_dat_i <= phy_mem[m_addr[5:0]]; rd_cnt <= rd_cnt + 1; end
      end else cnt <= cnt - 1;
    end else if (phy_ack && !any_stb) begin
      if (cnt <= 0) begin phy_ack <= 0; cnt <= ack_dly; phy_dat_i <= 16'hBEEF; end
      else cnt <= cnt - 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic poll(input logic [7:0] a, input string req);
    logic [31:0] v;
    v = 1;
    for (int i = 0; i < 100; i++) begin
      hrd(a, v);
      if (v[0] == 0) break;
    end
    check(req, v, 0);
  endtask

  task automatic phy_write(input logic [31:0] a, input logic [31:0] d);
    hwr(A_DIN, a); hwr(A_CAPA, 1); poll(A_CAPA, "R3 capa done");
    hwr(A_DIN, d); hwr(A_CAPD, 1); poll(A_CAPD, "R3 capd done");
    check("R5 data capture low half", 32'(m_data), 32'(d[15:0]));
    hwr(A_WR, 1); poll(A_WR, "R3 write done");
    exp_mem[a[5:0]] = d[15:0];
  endtask

  task automatic phy_read(input logic [31:0] a, output logic [31:0] v);
    hwr(A_DIN, a); hwr(A_CAPA, 1); poll(A_CAPA, "R3 capa done");
    check("R5 address capture low half", 32'(m_addr), 32'(a[15:0]));
    hwr(A_RD, 1); poll(A_RD, "R3 read done");
    hrd(A_DOUT, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] v, keep;
    int r0, w0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) begin phy_mem[i] = seed_val(i); exp_mem[i] = seed_val(i); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    hrd(A_CAPA, v); check("R1 capa after reset", v, 0);
    hrd(A_CAPD, v); check("R1 capd after reset", v, 0);
    hrd(A_RD, v);   check("R1 rd after reset", v, 0);
    hrd(A_WR, v);   check("R1 wr after reset", v, 0);
    hrd(A_DOUT, v); check("R1 result after reset", v, 0);
    check("R1 strobes after reset", 32'(any_stb), 0);

    hwr(A_DIN, 32'hCAFE_1234); hrd(A_DIN, v); check("R2 staging readback", v, 32'hCAFE_1234);

    // R3 / R4 timing with a slow PHY
    ack_dly = 3;
    hwr(A_DIN, 32'h0000_1006); hwr(A_CAPA, 1);
    check("R3 strobe raised", 32'(phy_cap_addr), 1);
    hrd(A_CAPA, v); check("R3 trigger busy", v, 1);
    begin
      bit done = 0;
      for (int i = 0; i < 40 && !done; i++) begin
        hrd(A_CAPA, v);
        if (phy_ack) check("R4 busy while ack high", v, 1);
        else if (v == 0) done = 1;
      end
      check("R4 clears after ack low", {31'd0, done}, 1);
    end

    // R7: triggers ignored while busy
    ack_dly = 6;
    r0 = rd_cnt; w0 = wr_cnt; hrd(A_DOUT, keep);
    hwr(A_DIN, 32'h0000_1010); hwr(A_CAPA, 1);
    hwr(A_RD, 1); hwr(A_WR, 1);
    hrd(A_RD, v);   check("R7 rd bit stays 0 when busy", v, 0);
    hrd(A_CAPA, v); check("R7 capa still busy", v, 1);
    poll(A_CAPA, "R7 capa done");
    repeat (10) @(negedge clk);
    check("R7 no read strobe served", 32'(rd_cnt), 32'(r0));
    check("R7 no write strobe served", 32'(wr_cnt), 32'(w0));
    hrd(A_DOUT, v); check("R6 result unchanged", v, keep);
    hwr(A_RD, 0); hrd(A_RD, v); check("R7 zero write idle", v, 0);
    repeat (4) @(negedge clk);
    check("R7 zero write no strobe", 32'(rd_cnt), 32'(r0));

    // R9 directed
    ack_dly = 0;
    phy_write(32'h0000_102D, 32'hFFFF_0080);
    phy_read(32'h0000_102D, v); check("R9 readback 102D", v, 32'h0000_0080);
    phy_write(32'hABCD_0030, 32'h1234_0000);
    phy_read(32'h0000_0030, v); check("R9 readback 30 zero", v, 0);
    phy_read(32'h0000_1002, v); check("R9 unwritten 1002", v, 32'(seed_val(2)));
    keep = v;
    phy_write(32'h0000_1010, 32'h0000_0020);
    hrd(A_DOUT, v); check("R6 result held across write", v, keep);

    // random
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a, d, got;
      a = $urandom; d = $urandom; ack_dly = $urandom_range(0, 3);
      phy_write(a, d);
      a = {$urandom, 6'(a[5:0])} ;
      a[5:0] = 6'($urandom);
      phy_read(a, got);
      check("R6 R9 random read", got, {16'd0, exp_mem[a[5:0]]});
    end
    check("R8 strobes idle at end", 32'(any_stb), 0);
    finish_up();
  end
endmodule